// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Controller with Set/Clear Registers

This block controls 32 general-purpose pins split into two banks of sixteen. Every per-pin property lives in its own feature register. The properties are:

- output level
- input enable
- output enable
- open-drain mode
- pull-up
- pull-down
- input inversion
- output inversion

Software never needs to read a register, modify it and write it back. A write carries a set mask in its low half and a clear mask in its high half. Only the pins named in those masks change.

The pad side gets:

- the drive level
- a drive enable that already accounts for open-drain mode
- the raw open-drain flag
- the two pull controls

Pad levels come back through a two-flop synchronizer. They are then inverted where requested and gated by input enable. The result is readable through a ninth, read-only register.

Register index is `bus_addr[3:0]` and `bus_addr[4]` selects the bank. Bank 0 holds pins 0 to 15 and bank 1 holds pins 16 to 31, using pin number modulo 16 as the bit position. The indices are:

| Index | Register |
|---|---|
| 0 | output level |
| 1 | input enable |
| 2 | output enable |
| 3 | open drain |
| 4 | pull-up |
| 5 | pull-down |
| 6 | input invert |
| 7 | output invert |
| 8 | input value (read-only) |
| 9 to 15 | unused |

Reads are combinational from the address.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every feature of every pin is clear, so every register reads 0 and `pad_oe`, `pad_od`, `pad_pu`, `pad_pd` and `pad_out` are all 0.
- R2: A write with bit n (n < 16) of `bus_wdata` set turns on the addressed feature for pin n of the addressed bank. The change is visible after the clock edge that takes the write.
- R3: A write with bit n+16 of `bus_wdata` set turns off the addressed feature for pin n of the addressed bank.
- R4: A pin whose set and clear bits are both 0 keeps its feature. When both are 1 the feature ends up clear. With `bus_we` low nothing changes.
- R5: `bus_addr[4]`=1 addresses pins 16 to 31, at bit (pin-16). `bus_addr[4]`=0 addresses pins 0 to 15. A write to one bank leaves the other bank untouched.
- R6: Reading indices 0 to 7 returns the bank's feature bits in `bus_rdata[15:0]`, with `bus_rdata[31:16]` equal to 0.
- R7: A pin not in open-drain mode drives `pad_out` = output level XOR output invert. Its `pad_oe` equals its output enable.
- R8: A pin in open-drain mode has `pad_out`=0. Its `pad_oe` is 1 only when output enable is set and the inverted output level is 0.
- R9: `pad_od`, `pad_pu` and `pad_pd` follow the open-drain, pull-up and pull-down features of each pin.
- R10: Index 8 returns (synchronized pad level XOR input invert) AND input enable for the bank's pins in bits 15:0. A change on `pad_in` shows up there two clock edges later.
- R11: Writes to index 8 and to unused indices 9 to 15 change no feature. Unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Bank select in bit 4 and register index in bits 3:0 |
| bus_wdata | input | 32 | Set mask in bits 15:0, clear mask in bits 31:16 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Pad drive level |
| pad_oe | output | 32 | Pad drive enable |
| pad_od | output | 32 | Open-drain mode per pin |
| pad_pu | output | 32 | Pull-up enable per pin |
| pad_pd | output | 32 | Pull-down enable per pin |

## Verification
The bench sweeps every feature, bank and pin with lone set and lone clear writes. Swapping the banks, shifting the clear mask or changing the wrong register would each show up as a wrong readback on a neighbouring pin or register.

Writes with both bits 1 on a pin that is already set expose a design that lets set win. A long pseudo-random stream of writes, which also hits the read-only and unused indices, catches corrupted state and lost write protection.

The pad outputs are checked against a model in every open-drain, enable and inversion combination. A design that drives high in open-drain mode, or forgets output inversion, fails there. Input reads are checked after the synchronizer delay under random invert and enable masks.

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int BANK_W   = 16,
  parameter int NUM_FEAT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [4:0]            bus_addr,
  input  logic [2*BANK_W-1:0]   bus_wdata,
  output logic [2*BANK_W-1:0]   bus_rdata,
  input  logic [2*BANK_W-1:0]   pad_in,
  output logic [2*BANK_W-1:0]   pad_out,
  output logic [2*BANK_W-1:0]   pad_oe,
  output logic [2*BANK_W-1:0]   pad_od,
  output logic [2*BANK_W-1:0]   pad_pu,
  output logic [2*BANK_W-1:0]   pad_pd
);
  localparam int PINS  = 2 * BANK_W;
  localparam int IDX_W = 4;
  localparam int FI_W  = $clog2(NUM_FEAT);
  localparam int F_VAL = 0, F_IEN = 1, F_OEN = 2, F_ODR = 3;
  localparam int F_PUP = 4, F_PDN = 5, F_IINV = 6, F_OINV = 7;

  logic [BANK_W-1:0] ft [NUM_FEAT][2];
  logic [IDX_W-1:0]  idx;
  logic              bank;
  logic              feat_hit;
  logic [BANK_W-1:0] set_m, clr_m;

  assign idx      = bus_addr[IDX_W-1:0];
  assign bank     = bus_addr[IDX_W];
  assign feat_hit = idx < IDX_W'(NUM_FEAT);
  assign set_m    = bus_wdata[BANK_W-1:0];
  assign clr_m    = bus_wdata[PINS-1:BANK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FEAT; f++)
        for (int b = 0; b < 2; b++)
          ft[f][b] <= '0;
    end else if (bus_we && feat_hit) begin
      ft[idx[FI_W-1:0]][bank] <= (ft[idx[FI_W-1:0]][bank] | set_m) & ~clr_m;
    end
  end

  logic [PINS-1:0] val, ien, oen, odr, pup, pdn, iinv, oinv, drv;
  assign val  = {ft[F_VAL][1],  ft[F_VAL][0]};
  assign ien  = {ft[F_IEN][1],  ft[F_IEN][0]};
  assign oen  = {ft[F_OEN][1],  ft[F_OEN][0]};
  assign odr  = {ft[F_ODR][1],  ft[F_ODR][0]};
  assign pup  = {ft[F_PUP][1],  ft[F_PUP][0]};
  assign pdn  = {ft[F_PDN][1],  ft[F_PDN][0]};
  assign iinv = {ft[F_IINV][1], ft[F_IINV][0]};
  assign oinv = {ft[F_OINV][1], ft[F_OINV][0]};

  assign drv     = val ^ oinv;
  assign pad_out = drv & ~odr;
  assign pad_oe  = oen & (~odr | ~drv);
  assign pad_od  = odr;
  assign pad_pu  = pup;
  assign pad_pd  = pdn;

  logic [PINS-1:0] sync1, sync2, in_val;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end
  assign in_val = (sync2 ^ iinv) & ien;

  always_comb begin
    bus_rdata = '0;
    if (feat_hit)
      bus_rdata[BANK_W-1:0] = ft[idx[FI_W-1:0]][bank];
    else if (idx == IDX_W'(NUM_FEAT))
      bus_rdata[BANK_W-1:0] = bank ? in_val[PINS-1:BANK_W] : in_val[BANK_W-1:0];
  end

  logic              chk_v, chk_b;
  logic [FI_W-1:0]   chk_f;
  logic [BANK_W-1:0] chk_set, chk_clr, chk_old, chk_oth;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v <= 1'b0; chk_b <= 1'b0; chk_f <= '0;
      chk_set <= '0; chk_clr <= '0; chk_old <= '0; chk_oth <= '0;
    end else begin
      chk_v   <= bus_we && feat_hit;
      chk_b   <= bank;
      chk_f   <= idx[FI_W-1:0];
      chk_set <= set_m;
      chk_clr <= clr_m;
      chk_old <= ft[idx[FI_W-1:0]][bank];
      chk_oth <= ft[idx[FI_W-1:0]][!bank];
    end
  end

  assert_set_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> ((~ft[chk_f][chk_b] & chk_set & ~chk_clr) == '0));
  assert_clear_applied_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> ((ft[chk_f][chk_b] & chk_clr) == '0));
  assert_untouched_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> (((ft[chk_f][chk_b] ^ chk_old) & ~(chk_set | chk_clr)) == '0));
  assert_other_bank_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> (ft[chk_f][!chk_b] == chk_oth));
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[PINS-1:BANK_W] == '0);
  assert_oe_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~oen) == '0);
  assert_od_no_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & (pad_out | (pad_oe & drv))) == '0);
  assert_in_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_val & ~ien) == '0);
endmodule

// File: tb/tb_gpio_setclr_bank.sv
`timescale 1ns/1ps
module tb_gpio_setclr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;

  gpio_setclr_bank dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] m [8];
  logic [31:0] rng = 32'h1234_5678;
  bit done = 0;

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a[3:0] < 8)
      m[a[2:0]][a[4]*16 +: 16] = (m[a[2:0]][a[4]*16 +: 16] | d[15:0]) & ~d[31:16];
  endtask

  task automatic rd(logic [4:0] a, string req, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic check_pads();
    logic [31:0] drv;
    drv = m[0] ^ m[7];
    chk("R7/R8 pad_out", pad_out, drv & ~m[3]);
    chk("R7/R8 pad_oe", pad_oe, m[2] & (~m[3] | ~drv));
    chk("R9 pad_od", pad_od, m[3]);
    chk("R9 pad_pu", pad_pu, m[4]);
    chk("R9 pad_pd", pad_pd, m[5]);
  endtask

  task automatic check_all(string req);
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 8; f++)
        rd(5'(b*16 + f), req, {16'h0, m[f][b*16 +: 16]});
    check_pads();
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 8; f++) m[f] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    for (int a = 8; a < 16; a++) rd(5'(a), "R1/R11 idle read", 32'h0);

    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 8; f++)
        for (int p = 0; p < 16; p++) begin
          wr(5'(b*16 + f), 32'h1 << p);
          rd(5'(b*16 + f), "R2/R5 set", {16'h0, m[f][b*16 +: 16]});
          rd(5'((1-b)*16 + f), "R5 other bank", {16'h0, m[f][(1-b)*16 +: 16]});
        end
    check_all("R2 all set");

    wr(5'h00, 32'h0001_0001);
    rd(5'h00, "R4 clear wins", 32'h0000_FFFE);
    wr(5'h13, 32'h8000_8000);
    rd(5'h13, "R4 clear wins high", 32'h0000_7FFF);

    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 8; f++)
        for (int p = 0; p < 16; p++) begin
          wr(5'(b*16 + f), 32'h1 << (p + 16));
          rd(5'(b*16 + f), "R3 clear", {16'h0, m[f][b*16 +: 16]});
        end
    check_all("R3 all clear");

    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      rng = nxt(rng); a = rng[4:0];
      rng = nxt(rng);
      wr(a, rng & nxt(rng));
      if (a[3:0] >= 8) rd(a & 5'h17, "R11 no effect", {16'h0, m[a[2:0]][a[4]*16 +: 16]});
      if (i % 8 == 0) check_all("R4/R6 random");
      check_pads();
    end

    for (int i = 0; i < 40; i++) begin
      rng = nxt(rng); wr(5'h01, rng);
      rng = nxt(rng); wr(5'h11, rng);
      rng = nxt(rng); wr(5'h06, rng);
      rng = nxt(rng); wr(5'h16, rng);
      rng = nxt(rng); pad_in = rng;
      @(negedge clk); @(negedge clk);
      rd(5'h08, "R10 input low", {16'h0, ((pad_in ^ m[6]) & m[1]) >> 0 & 32'hFFFF});
      rd(5'h18, "R10 input high", {16'h0, ((pad_in ^ m[6]) & m[1]) >> 16});
      for (int a = 9; a < 16; a++) rd(5'(a), "R11 unused read", 32'h0);
    end

    pad_in = 32'hFFFF_FFFF;
    wr(5'h01, 32'h0000_FFFF);
    wr(5'h06, 32'hFFFF_0000);
    pad_in = 32'h0;
    @(negedge clk);
    rd(5'h08, "R10 sync delay", 32'h0000_FFFF);
    @(negedge clk);
    rd(5'h08, "R10 after sync", 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule